// File: doc/BRIEF.md
# Two-Cycle Pipelined Synchronous SRAM Without Turnaround

This block is a single-port synchronous memory for use as an on-chip memory model. On every active rising clock edge it accepts one command: load a new address or continue a burst, with a direction flag and three chip-select inputs. The data that belongs to that command moves exactly two active edges later. A read result leaves on a registered output bus. Write data and its per-lane keep mask are sampled from the input bus at that edge. Reads and writes use the same two-cycle spacing, so commands of either kind can follow each other on every cycle with no idle slot.

A 2-bit burst counter produces three more addresses after each load, in linear order or in interleaved order. When the active-low clock enable is high, the whole pipeline freezes. A load cycle with the block deselected starts nothing and ends any running burst, but transfers already in the pipeline still finish. A separate output-valid flag stands in for a tri-stated data bus.

Top module: `pipe_sram`

## Requirements
- R1: A read accepted on active edge N drives `rdata` with the addressed word, and sets `rdata_oe` to 1, at active edge N+2.
- R2: For a write accepted on active edge N, `wdata` and `lane_keep_n` are sampled at active edge N+2. Lane i is bits [9i+8:9i]. It is written only when `lane_keep_n[i]` is 0, and the other lanes keep their contents.
- R3: While `cke_n` is 1, every input is ignored. No memory word changes, and `rdata` and `rdata_oe` hold their values. The pipeline then resumes where it stopped.
- R4: Reads and writes can be mixed on consecutive cycles with no idle cycle. A read accepted one cycle after a write to the same address returns the newly written lanes.
- R5: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load (`load_n`=0) while not selected starts no operation and ends any burst in progress.
- R6: `load_n`=1 after a selected load continues the burst in the direction of the load. At the k-th advance (k counted modulo 4, and the count wraps around), the two low address bits are (base+k) mod 4 when `ilv_mode`=0, and base XOR k when `ilv_mode`=1. The upper address bits are unchanged.
- R7: `load_n`=1 with no burst in progress, for example after reset or after a deselect, is a no-operation.
- R8: Two active edges after a write command, a deselect or a no-operation, `rdata_oe` is 0 and `rdata` is 0.
- R9: After reset, `rdata_oe` is 0, `rdata` is 0 and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; high freezes the pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 loads `addr`, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write (sampled on load) |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| lane_keep_n | input | LANES | Per-lane write mask, 0 writes the lane |
| wdata | input | LANES*LANE_W | Write data, sampled two active edges after the command |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | High when `rdata` carries a read result |

## Verification
Every result is due exactly two active edges after its command. A read shows on `rdata` and `rdata_oe`, and a write takes its data and mask at that edge. Edges with `cke_n` high do not count. The bench keeps a reference memory and a two-deep model pipeline that advances only on edges where the model sees `cke_n` low. It applies pending writes before it predicts reads, and it compares the outputs on the falling edge after each rising edge. This way stalls, back-to-back direction changes and a read right after a write to the same address all line up with the expected cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  // Low two address bits for burst step k relative to the loaded base.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] k,
                                           input burst_ord_e ord);
    if (ord == ORD_XOR) return base ^ k;
    return base + k;
  endfunction

endpackage

// File: rtl/pipe_sram_cmd.sv
module pipe_sram_cmd
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              load_n,
  input  logic              rd_wr_n,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              op_vld,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr
);

  logic              live;
  logic              live_wr;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [1:0]        cnt_nx;

  assign cnt_nx = cnt + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      live_wr <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      op_vld  <= 1'b0;
      op_wr   <= 1'b0;
      op_addr <= '0;
    end else if (adv) begin
      if (!load_n) begin
        live    <= sel_ok;
        live_wr <= ~rd_wr_n;
        base    <= addr;
        cnt     <= '0;
        op_vld  <= sel_ok;
        op_wr   <= ~rd_wr_n;
        op_addr <= addr;
      end else begin
        if (live) cnt <= cnt_nx;
        op_vld  <= live;
        op_wr   <= live_wr;
        op_addr <= {base[ADDR_W-1:2],
                    burst_low(base[1:0], cnt_nx, burst_ord_e'(ilv_mode))};
      end
    end
  end

endmodule

// File: rtl/pipe_sram_lane.sv
module pipe_sram_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    if (re) rd <= mem[raddr];
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cke_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     load_n,
  input  logic                     rd_wr_n,
  input  logic                     ilv_mode,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         lane_keep_n,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic                     rdata_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              adv;
  logic              sel_ok;
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic              s2_vld, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic              wr_now;
  logic              byp_hit;
  logic [DATA_W-1:0] byp_data;
  logic [LANES-1:0]  byp_keep_n;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] merged;
  logic              rd_due;

  assign adv    = ~cke_n;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;
  assign wr_now = adv & s2_vld & s2_wr;
  assign rd_due = s2_vld & ~s2_wr;

  pipe_sram_cmd #(.ADDR_W(ADDR_W)) cmd_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .sel_ok  (sel_ok),
    .load_n  (load_n),
    .rd_wr_n (rd_wr_n),
    .ilv_mode(ilv_mode),
    .addr    (addr),
    .op_vld  (s1_vld),
    .op_wr   (s1_wr),
    .op_addr (s1_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld     <= 1'b0;
      s2_wr      <= 1'b0;
      s2_addr    <= '0;
      byp_hit    <= 1'b0;
      byp_data   <= '0;
      byp_keep_n <= '1;
    end else if (adv) begin
      s2_vld     <= s1_vld;
      s2_wr      <= s1_wr;
      s2_addr    <= s1_addr;
      byp_hit    <= s1_vld & ~s1_wr & s2_vld & s2_wr & (s1_addr == s2_addr);
      byp_data   <= wdata;
      byp_keep_n <= lane_keep_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pipe_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) ram_i (
      .clk  (clk),
      .we   (wr_now & ~lane_keep_n[g]),
      .waddr(s2_addr),
      .wd   (wdata[g*LANE_W +: LANE_W]),
      .re   (adv),
      .raddr(s1_addr),
      .rd   (ram_q[g*LANE_W +: LANE_W])
    );
    assign merged[g*LANE_W +: LANE_W] = (byp_hit && !byp_keep_n[g])
                                        ? byp_data[g*LANE_W +: LANE_W]
                                        : ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (adv) begin
      rdata_oe <= rd_due;
      rdata    <= rd_due ? merged : '0;
    end
  end

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cke_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              load_n,
  input logic              rd_wr_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe
);

  // Independent model of which accepted slots are reads.
  logic live, live_rd, p1, p2;
  logic sel_ok;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      live_rd <= 1'b0;
      p1      <= 1'b0;
      p2      <= 1'b0;
    end else if (!cke_n) begin
      if (!load_n) begin
        live    <= sel_ok;
        live_rd <= rd_wr_n;
      end
      p1 <= !load_n ? (sel_ok & rd_wr_n) : (live & live_rd);
      p2 <= p1;
    end
  end

  a_r1_read_due: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && p2) |=> rdata_oe);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !p2) |=> (!rdata_oe && rdata == '0));

  a_r3_stall_oe: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(rdata_oe));

  a_r3_stall_data: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(rdata));

endmodule

bind pipe_sram pipe_sram_chk #(.DATA_W(LANES*LANE_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cke_n   (cke_n),
  .sel_a_n (sel_a_n),
  .sel_b   (sel_b),
  .sel_c_n (sel_c_n),
  .load_n  (load_n),
  .rd_wr_n (rd_wr_n),
  .rdata   (rdata),
  .rdata_oe(rdata_oe)
);

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb_top;

  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          cke_n, sel_a_n, sel_b, sel_c_n, load_n, rd_wr_n, ilv_mode;
  logic [AW-1:0] addr;
  logic [LN-1:0] lane_keep_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .load_n(load_n), .rd_wr_n(rd_wr_n), .ilv_mode(ilv_mode),
    .addr(addr), .lane_keep_n(lane_keep_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // Reference model
  logic [DW-1:0] refmem [DEPTH];
  logic          m1_vld, m1_wr, m2_vld, m2_wr;
  logic [AW-1:0] m1_addr, m2_addr;
  logic          b_live, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  logic          exp_oe;
  logic [DW-1:0] exp_rd;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] base,
                                              input logic [1:0] k,
                                              input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], lo};
  endfunction

  task automatic model_reset();
    m1_vld = 0; m1_wr = 0; m1_addr = '0;
    m2_vld = 0; m2_wr = 0; m2_addr = '0;
    b_live = 0; b_wr = 0; b_base = '0; b_cnt = '0;
    exp_oe = 0; exp_rd = '0;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic cke, input logic ld, input logic sel,
                       input logic rd, input logic ilv, input logic [AW-1:0] a);
    cke_n    = cke;
    load_n   = ld;
    sel_a_n  = ~sel;
    sel_b    = 1'b1;
    sel_c_n  = 1'b0;
    rd_wr_n  = rd;
    ilv_mode = ilv;
    addr     = a;
    wdata    = {$urandom(), $urandom()} & {DW{1'b1}};
    lane_keep_n = LN'($urandom());
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (!cke_n) begin
      if (m2_vld && m2_wr)
        for (int l = 0; l < LN; l++)
          if (!lane_keep_n[l]) refmem[m2_addr][l*LW +: LW] = wdata[l*LW +: LW];
      exp_oe = m2_vld && !m2_wr;
      exp_rd = exp_oe ? refmem[m2_addr] : '0;
      m2_vld = m1_vld; m2_wr = m1_wr; m2_addr = m1_addr;
      if (!load_n) begin
        b_live = !sel_a_n && sel_b && !sel_c_n;
        b_wr   = !rd_wr_n;
        b_base = addr;
        b_cnt  = 2'd0;
        m1_vld = b_live; m1_wr = b_wr; m1_addr = addr;
      end else begin
        if (b_live) b_cnt = b_cnt + 2'd1;
        m1_vld  = b_live;
        m1_wr   = b_wr;
        m1_addr = step_addr(b_base, b_cnt, ilv_mode);
      end
    end
    @(negedge clk);
    check(tag, DW'(rdata_oe), DW'(exp_oe), "rdata_oe");
    check(tag, rdata, exp_rd, "rdata");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    rst = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9", DW'(rdata_oe), '0, "rdata_oe after reset");
    check("R9", rdata, '0, "rdata after reset");
    // R7: advance with no burst is a no-op
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(i));
      tick("R7");
    end
    // R2: fill memory with back-to-back write bursts, all lanes written
    for (int b = 0; b < DEPTH; b += 4) begin
      for (int k = 0; k < 4; k++) begin
        drive(1'b0, (k == 0) ? 1'b0 : 1'b1, 1'b1, 1'b0, 1'b0, AW'(b));
        lane_keep_n = '0;
        tick("R2");
      end
    end
    // R8: deselect loads drain the pipe; oe must fall
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
      lane_keep_n = '0;
      tick("R8");
    end
    // R6: linear burst from low bits 01, then interleaved from 10
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd5); tick("R6");
    for (int k = 0; k < 5; k++) begin drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0); tick("R6"); end
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd38); tick("R6");
    for (int k = 0; k < 5; k++) begin drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0); tick("R6"); end
    // R4: write addr 9, read it the next cycle with a partial mask
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9); tick("R4");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd9); tick("R4");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd9); lane_keep_n = 4'b1010; tick("R4");
    for (int i = 0; i < 3; i++) begin drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0); tick("R4"); end
    // R3: stall inside a read burst with a write load on the pins
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd20); tick("R3");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0); tick("R3");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0); tick("R3");
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd20); lane_keep_n = '0; tick("R3");
    end
    for (int i = 0; i < 4; i++) begin drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0); tick("R3"); end
    // R5: deselect mid burst ends it; in-flight reads finish
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd44); tick("R5");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0); tick("R5");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0); tick("R5");
    for (int i = 0; i < 4; i++) begin drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0); tick("R5"); end
    // R1: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom_range(0, 9) == 0), ($urandom_range(0, 9) < 6),
            ($urandom_range(0, 19) != 0), $urandom_range(0, 1),
            $urandom_range(0, 1), AW'($urandom()));
      tick("R1");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule